// File: doc/BRIEF.md
# Mute and Power State Sequencer

This block decides, from three control observations, whether an audio output path is off, idling in standby or playing. The observations are a flag that the master clock is running, a flag that the bit clock is running and an active-low mute pin. It also controls the gain of the stereo sample stream that passes through it. While samples keep arriving, a mute request fades the gain down in equal steps, one step per sample. If no samples arrive, the output is cut in one step after a short timeout. Releasing the mute restores full gain at once.

The sequencer has four states, carried on `pwr_state`:

- `PS_OFF` (0): the master clock is absent.
- `PS_STANDBY` (1): the charge pump runs and the output is silent.
- `PS_ENABLE` (2): samples pass through unchanged.
- `PS_MUTING` (3): the fade-out or the no-data timeout is in progress.

The named transitions are:

- **power-up-play**: OFF to ENABLE.
- **power-up-quiet**: OFF to STANDBY.
- **wake**: STANDBY to ENABLE.
- **mute-start**: ENABLE to MUTING.
- **unmute**: MUTING to ENABLE.
- **mute-done**: MUTING to STANDBY.
- **clock-loss**: any state to OFF.

The block drives two enables, one for the charge pump and one for the line-output stage.

Top module: `mute_power_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `pwr_state` is 0 (OFF), `cp_en`, `drv_en` and `out_valid` are 0, and both sample outputs are 0.
- R2: In OFF, with `mclk_ok` and `bclk_ok` both 1, the next state is ENABLE (2) if `mute_n` is 1 and STANDBY (1) if `mute_n` is 0. If either clock flag is 0, the state stays OFF.
- R3: `mclk_ok` at 0 moves any state to OFF at the next clock edge. This check has priority over every other transition.
- R4: STANDBY is held while `bclk_ok` is 0, even when `mute_n` is 1. STANDBY moves to ENABLE only when `mute_n` and `bclk_ok` are both 1 (with `mclk_ok` 1).
- R5: ENABLE moves to MUTING (3) at the next edge when `mute_n` is 0 or `bclk_ok` is 0.
- R6: `out_valid` repeats `smp_valid` one cycle later. In ENABLE, each accepted sample appears unchanged on `out_left`/`out_right` one cycle after it is accepted.
- R7: In MUTING, the n-th accepted sample (n = 1..RAMP_STEPS, default 944) is output as floor(s × (944 − n) × 69 / 65536) on both channels. Here 69 = floor(65536 / 944) is the gain step. One cycle after the output of the 944th sample, the state is STANDBY.
- R8: In MUTING, when 4 × PERIOD_CYC consecutive clock cycles pass with no sample, the state moves to STANDBY. With samples arriving, this timeout does not occur.
- R9: In MUTING, `mute_n` = 1 together with `bclk_ok` = 1 returns the state to ENABLE at the next edge. The next sample then passes at full gain.
- R10: `cp_en` is 1 in every state except OFF. `drv_en` is 1 only in ENABLE and MUTING.
- R11: In OFF and STANDBY, every sample output with `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per stereo sample |
| smp_left | input | DW | Left sample, two's complement |
| smp_right | input | DW | Right sample, two's complement |
| mute_n | input | 1 | Mute request, 0 = mute, 1 = play |
| bclk_ok | input | 1 | Bit clock detected as running |
| mclk_ok | input | 1 | Master clock detected as running |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | DW | Gain-scaled left sample |
| out_right | output | DW | Gain-scaled right sample |
| pwr_state | output | 2 | Current state: 0 OFF, 1 STANDBY, 2 ENABLE, 3 MUTING |
| cp_en | output | 1 | Charge-pump enable |
| drv_en | output | 1 | Output-stage enable |

## Verification
A wrong state shows on `pwr_state` and the enables one cycle after the input that caused it. A wrong gain count shows on the next accepted sample after a mute request, because the exact fade value of every one of the 944 steps is compared. An idle timer that is off by one cycle moves the mute-done transition by a cycle, and the directed timeout cases sample that transition on both sides of its boundary. Wrong state-dependent zeroing shows as a non-zero sample in standby or off.

// File: rtl/mps_pkg.sv
package mps_pkg;
    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_STANDBY = 2'd1,
        PS_ENABLE  = 2'd2,
        PS_MUTING  = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/mps_fsm.sv
module mps_fsm
    import mps_pkg::*;
#(
    parameter int HOLD_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_ok,
    input  logic       bclk_ok,
    input  logic       mute_n,
    input  logic       smp_valid,
    input  logic       ramp_done,
    output pwr_state_t state_q,
    output pwr_state_t state_nxt,
    output logic       cp_en,
    output logic       drv_en
);
    localparam int IW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [IW-1:0] IDLE_LAST = IW'(HOLD_CYC - 1);

    logic [IW-1:0] idle_q;
    logic          idle_expire;

    assign idle_expire = (idle_q == IDLE_LAST) && !smp_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_nxt;
    end

    // idle timer: sample-free cycles while muting
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != PS_MUTING || smp_valid) idle_q <= '0;
        else if (idle_q != IDLE_LAST)                    idle_q <= idle_q + 1'b1;
    end

    always_comb begin
        state_nxt = state_q;
        if (!mclk_ok) begin
            state_nxt = PS_OFF;                              // clock-loss
        end else begin
            unique case (state_q)
                PS_OFF:
                    if (bclk_ok) state_nxt = mute_n ? PS_ENABLE : PS_STANDBY;
                PS_STANDBY:
                    if (bclk_ok && mute_n) state_nxt = PS_ENABLE;    // wake
                PS_ENABLE:
                    if (!bclk_ok || !mute_n) state_nxt = PS_MUTING;  // mute-start
                PS_MUTING:
                    if (bclk_ok && mute_n)          state_nxt = PS_ENABLE;  // unmute
                    else if (ramp_done || idle_expire) state_nxt = PS_STANDBY; // mute-done
            endcase
        end
    end

    // outputs
    always_comb begin
        cp_en  = 1'b0;
        drv_en = 1'b0;
        unique case (state_q)
            PS_OFF:     ;
            PS_STANDBY: cp_en = 1'b1;
            PS_ENABLE,
            PS_MUTING:  begin cp_en = 1'b1; drv_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/mps_ramp.sv
module mps_ramp
    import mps_pkg::*;
#(
    parameter int STEPS = 944,
    parameter int GW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pwr_state_t    state_q,
    input  pwr_state_t    state_nxt,
    input  logic          smp_valid,
    output logic          ramp_done,
    output logic [GW-1:0] gain_q
);
    localparam int KW = $clog2(STEPS + 1);
    localparam int PW = KW + GW;
    localparam logic [PW-1:0] STEP_Q = PW'((64'd1 << GW) / STEPS);

    logic [KW-1:0] k_q;
    logic [PW-1:0] k_ext;
    logic [PW-1:0] prod;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q <= '0;
        end else begin
            unique case (state_nxt)
                PS_OFF, PS_STANDBY: k_q <= '0;
                PS_ENABLE:          k_q <= KW'(STEPS);
                PS_MUTING:
                    if (state_q == PS_MUTING && smp_valid && k_q != '0) k_q <= k_q - 1'b1;
            endcase
        end
    end

    assign ramp_done = (k_q == '0);
    assign k_ext     = PW'(k_q) - PW'(1);
    assign prod      = k_ext * STEP_Q;
    assign gain_q    = ramp_done ? '0 : prod[GW-1:0];
endmodule

// File: rtl/mps_gain.sv
module mps_gain
    import mps_pkg::*;
#(
    parameter int DW  = 24,
    parameter int GW  = 16,
    parameter int NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  pwr_state_t              state_q,
    input  logic [GW-1:0]           gain_q,
    input  logic                    smp_valid,
    input  logic [NCH-1:0][DW-1:0]  smp_in,
    output logic                    out_valid,
    output logic [NCH-1:0][DW-1:0]  smp_out
);
    localparam int MW = DW + GW + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= smp_valid;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic signed [MW-1:0] a_s, g_s, prod_s, shr_s;
        assign a_s    = $signed({{(GW+1){smp_in[ch][DW-1]}}, smp_in[ch]});
        assign g_s    = $signed({{(DW+1){1'b0}}, gain_q});
        assign prod_s = a_s * g_s;
        assign shr_s  = prod_s >>> GW;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_out[ch] <= '0;
            end else if (smp_valid) begin
                unique case (state_q)
                    PS_ENABLE:          smp_out[ch] <= smp_in[ch];
                    PS_MUTING:          smp_out[ch] <= shr_s[DW-1:0];
                    PS_OFF, PS_STANDBY: smp_out[ch] <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mute_power_seq.sv
module mute_power_seq
    import mps_pkg::*;
#(
    parameter int DW           = 24,
    parameter int GW           = 16,
    parameter int RAMP_STEPS   = 944,
    parameter int PERIOD_CYC   = 16,
    parameter int HOLD_SAMPLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_left,
    input  logic [DW-1:0] smp_right,
    input  logic          mute_n,
    input  logic          bclk_ok,
    input  logic          mclk_ok,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic [1:0]    pwr_state,
    output logic          cp_en,
    output logic          drv_en
);
    localparam int HOLD_CYC = PERIOD_CYC * HOLD_SAMPLES;
    localparam int NCH      = 2;

    pwr_state_t             state_q, state_nxt;
    logic                   ramp_done;
    logic [GW-1:0]          gain_q;
    logic [NCH-1:0][DW-1:0] smp_in, smp_out;

    assign smp_in    = {smp_right, smp_left};
    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];
    assign pwr_state = state_q;

    mps_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mclk_ok(mclk_ok), .bclk_ok(bclk_ok),
        .mute_n(mute_n), .smp_valid(smp_valid), .ramp_done(ramp_done),
        .state_q(state_q), .state_nxt(state_nxt), .cp_en(cp_en), .drv_en(drv_en)
    );

    mps_ramp #(.STEPS(RAMP_STEPS), .GW(GW)) u_ramp (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_nxt(state_nxt),
        .smp_valid(smp_valid), .ramp_done(ramp_done), .gain_q(gain_q)
    );

    mps_gain #(.DW(DW), .GW(GW), .NCH(NCH)) u_gain (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .gain_q(gain_q),
        .smp_valid(smp_valid), .smp_in(smp_in), .out_valid(out_valid),
        .smp_out(smp_out)
    );
endmodule

// File: rtl/mute_power_seq_chk.sv
module mute_power_seq_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [DW-1:0] smp_left,
    input logic [DW-1:0] smp_right,
    input logic          mute_n,
    input logic          bclk_ok,
    input logic          mclk_ok,
    input logic          out_valid,
    input logic [DW-1:0] out_left,
    input logic [DW-1:0] out_right,
    input logic [1:0]    pwr_state,
    input logic          cp_en,
    input logic          drv_en
);
    a_r3_mclk_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_ok |=> pwr_state == 2'd0);

    a_r10_drv_needs_cp: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> cp_en);

    a_r4_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 && mclk_ok && !(mute_n && bclk_ok)) |=> pwr_state == 2'd1);

    a_r9_unmute_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && mclk_ok && mute_n && bclk_ok) |=> pwr_state == 2'd2);

    a_r5_mute_start: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 && mclk_ok && (!mute_n || !bclk_ok)) |=> pwr_state == 2'd3);

    a_r6_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(smp_valid));

    a_r6_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(smp_valid) && $past(pwr_state) == 2'd2)
            |-> (out_left == $past(smp_left) && out_right == $past(smp_right)));

    a_r11_silent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(pwr_state) <= 2'd1) |-> (out_left == '0 && out_right == '0));
endmodule

bind mute_power_seq mute_power_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/mute_power_seq_bench.sv
module mute_power_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int STEPS      = 944;
    localparam int PER        = 8;
    localparam int HOLD       = 4 * PER;
    localparam longint GSTEP  = 65536 / 944;

    logic          clk = 1'b0;
    logic          rst_n, smp_valid, mute_n, bclk_ok, mclk_ok;
    logic [DW-1:0] smp_left, smp_right;
    logic          out_valid, cp_en, drv_en;
    logic [DW-1:0] out_left, out_right;
    logic [1:0]    pwr_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mute_power_seq #(.DW(DW), .RAMP_STEPS(STEPS), .PERIOD_CYC(PER)) u_mute_power_seq (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .mute_n(mute_n), .bclk_ok(bclk_ok), .mclk_ok(mclk_ok),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .pwr_state(pwr_state), .cp_en(cp_en), .drv_en(drv_en)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input longint l, input longint r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = DW'(l);
        smp_right = DW'(r);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    function automatic longint sx(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint ramp_exp(input longint s, input int n);
        return (s * (longint'(STEPS - n) * GSTEP)) >>> 16;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; smp_valid = 1'b0; smp_left = '0; smp_right = '0;
        mute_n = 1'b1; bclk_ok = 1'b1; mclk_ok = 1'b1;
        tick(3);
        chk("R1 state in reset", pwr_state, 0);
        chk("R1 cp_en in reset", cp_en, 0);
        chk("R1 drv_en in reset", drv_en, 0);
        chk("R1 out_valid in reset", out_valid, 0);
        mclk_ok = 1'b0; bclk_ok = 1'b0;
        rst_n = 1'b1;
        tick(1);
        chk("R1 state after release", pwr_state, 0);
        chk("R1 out_left after release", sx(out_left), 0);
    endtask

    task automatic t_off_stays();
        mclk_ok = 1'b1; bclk_ok = 1'b0; mute_n = 1'b1;
        tick(3);
        chk("R2 off without bit clock", pwr_state, 0);
        send(1234, -77);
        chk("R11 off output zero", sx(out_left), 0);
        chk("R6 out_valid follows in off", out_valid, 1);
    endtask

    task automatic t_power_play();
        bclk_ok = 1'b1;
        tick(1);
        chk("R2 off to enable", pwr_state, 2);
        chk("R10 cp_en in enable", cp_en, 1);
        chk("R10 drv_en in enable", drv_en, 1);
    endtask

    task automatic t_pass();
        send(8388607, -8388608);
        chk("R6 pass left max", sx(out_left), 8388607);
        chk("R6 pass right min", sx(out_right), -8388608);
        chk("R6 out_valid", out_valid, 1);
        send(-5, 4242);
        chk("R6 pass left small", sx(out_left), -5);
        chk("R6 pass right", sx(out_right), 4242);
        tick(1);
        chk("R6 out_valid drops", out_valid, 0);
    endtask

    task automatic t_ramp();
        mute_n = 1'b0;
        tick(1);
        chk("R5 enable to muting on mute", pwr_state, 3);
        chk("R10 drv_en while muting", drv_en, 1);
        for (int n = 1; n <= STEPS; n++) begin
            longint l = 8388607 - longint'(n) * 37;
            longint r = -(longint'(n) * 5000);
            send(l, r);
            chk("R7 ramp left", sx(out_left), ramp_exp(l, n));
            chk("R7 ramp right", sx(out_right), ramp_exp(r, n));
        end
        chk("R7 still muting at last sample", pwr_state, 3);
        tick(1);
        chk("R7 standby after ramp", pwr_state, 1);
        chk("R10 cp_en in standby", cp_en, 1);
        chk("R10 drv_en off in standby", drv_en, 0);
    endtask

    task automatic t_standby();
        bclk_ok = 1'b0;
        tick(3);
        chk("R4 standby holds without bit clock", pwr_state, 1);
        send(999, -999);
        chk("R11 standby output zero", sx(out_left), 0);
        chk("R11 standby output zero right", sx(out_right), 0);
        mute_n = 1'b1;
        tick(3);
        chk("R4 standby needs bit clock", pwr_state, 1);
        bclk_ok = 1'b1;
        tick(1);
        chk("R4 standby to enable", pwr_state, 2);
        send(300, -300);
        chk("R4 enable passes after wake", sx(out_left), 300);
    endtask

    task automatic t_idle_mute();
        mute_n = 1'b0;
        tick(1);
        chk("R8 muting entered", pwr_state, 3);
        tick(HOLD - 1);
        chk("R8 still muting before timeout", pwr_state, 3);
        tick(1);
        chk("R8 standby after timeout", pwr_state, 1);
    endtask

    task automatic t_unmute();
        mute_n = 1'b1;
        tick(1);
        chk("R4 wake", pwr_state, 2);
        mute_n = 1'b0;
        tick(1);
        for (int n = 1; n <= 10; n++) begin
            send(100000, -100000);
            chk("R7 partial ramp", sx(out_left), ramp_exp(100000, n));
        end
        mute_n = 1'b1;
        tick(1);
        chk("R9 unmute step", pwr_state, 2);
        send(100000, -100000);
        chk("R9 full gain left", sx(out_left), 100000);
        chk("R9 full gain right", sx(out_right), -100000);
    endtask

    task automatic t_bclk_loss();
        bclk_ok = 1'b0;
        tick(1);
        chk("R5 enable to muting on bit clock loss", pwr_state, 3);
        tick(HOLD);
        chk("R8 standby after bit clock loss", pwr_state, 1);
    endtask

    task automatic t_mclk_loss();
        bclk_ok = 1'b1; mute_n = 1'b1;
        tick(1);
        chk("R4 wake again", pwr_state, 2);
        mclk_ok = 1'b0;
        tick(1);
        chk("R3 enable to off", pwr_state, 0);
        chk("R10 cp_en off", cp_en, 0);
        chk("R10 drv_en off", drv_en, 0);
        mute_n = 1'b0; mclk_ok = 1'b1;
        tick(1);
        chk("R2 off to standby", pwr_state, 1);
        mclk_ok = 1'b0;
        tick(1);
        chk("R3 standby to off", pwr_state, 0);
        mute_n = 1'b1; mclk_ok = 1'b1;
        tick(1);
        chk("R2 off to enable again", pwr_state, 2);
        mute_n = 1'b0;
        tick(1);
        chk("R5 muting again", pwr_state, 3);
        mclk_ok = 1'b0;
        tick(1);
        chk("R3 muting to off", pwr_state, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_off_stays();
        t_power_play();
        t_pass();
        t_ramp();
        t_standby();
        t_idle_mute();
        t_unmute();
        t_bclk_loss();
        t_mclk_loss();
        tick(2);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule